// File: doc/BRIEF.md
# Sync-Header Frame Deframer with Station Address Filter

This block sits behind a despreader and turns a raw stream of recovered bits into framed bytes. Each received bit arrives with a one-cycle strobe. While idle, the block slides a 16-bit window over the incoming bits, one bit per strobe. It starts a frame only when the window holds the two-byte sync pattern 0x09 then 0xAF. From then on it groups every eight bits into a byte, first bit in the most significant position.

The first framed byte is the destination address and the second is the body length. The body bytes and a check byte follow. The block compares the address with the local station address. It passes body bytes to its output stream only for a matching frame. It checks the trailing byte against the modulo-256 sum of everything after the header. It pulses a completion flag for every finished frame, and this pulse carries a checksum-error indication with it. A length above the allowed maximum abandons the frame. After completion or abandonment the search window is emptied and hunting begins again.

Top module: `sync_frame_deframer`

## Requirements
- R1: After reset, `byte_vld`, `frame_done`, `csum_err` and `addr_match` are 0 and the block is searching for the header.
- R2: While searching, every strobed bit shifts into a 16-bit window, and a frame starts as soon as the window equals 16'h09AF, whatever the bit offset of the header in the stream. `bit_in` has no effect while `bit_vld` is low.
- R3: After the header, each group of 8 strobed bits forms one byte with the first bit as bit 7. The bytes are, in order: address, length, `length` body bytes, then the check byte.
- R4: `addr_match` becomes 1 (or 0) in the cycle after the last bit of the address byte, according to whether the address equals `station_addr`. It holds that value until the next header is found or the frame is abandoned.
- R5: Lengths 0 to 64 are accepted. A length above 64 abandons the frame: no `frame_done` follows, `addr_match` returns to 0 and header search restarts.
- R6: Body bytes appear on `byte_out` with a one-cycle `byte_vld`, in order and exactly `length` of them, only when `addr_match` is 1. Each appears in the cycle after the clock edge that samples the byte's last bit.
- R7: Every completed frame, matching or not, gives a one-cycle `frame_done` in the cycle after the edge that samples the last bit of the check byte.
- R8: `csum_err` is 1 exactly in a `frame_done` cycle whose check byte differs from the 8-bit sum, modulo 256, of the address, length and body bytes.
- R9: After `frame_done` or an abandonment the window starts empty, so a new frame needs all 16 header bits received afresh. An 0xAF alone does not start a frame.
- R10: A frame with length 0 consists of address, length and check byte. It completes with no `byte_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Despread data bit |
| bit_vld | input | 1 | One-cycle strobe qualifying `bit_in` |
| station_addr | input | 8 | Local station address |
| byte_out | output | 8 | Last delivered body byte |
| byte_vld | output | 1 | Pulse: `byte_out` carries a new body byte |
| frame_done | output | 1 | Pulse: a frame's check byte was received |
| addr_match | output | 1 | Current frame is addressed to this station |
| csum_err | output | 1 | With `frame_done`: check byte mismatch |

## Verification
Every result here is registered once after the clock edge that samples the deciding bit. A body byte, the address flag, the abort and the completion pulse with its error flag are all due in the cycle right after the strobe carrying the eighth bit of the relevant byte. The driver ends each byte with its last strobe and then stops at the following falling edge. The checks read the outputs directly at that point, so a result one cycle late or early is reported. A falling-edge monitor also collects every byte and completion pulse. The scenarios compare these collected counts and contents with values the bench computes from the address, length and body it sent. These include the bytes it must not receive, such as those of a foreign frame, an abandoned frame or a lone 0xAF.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_ADDR,
        PH_LEN,
        PH_BODY,
        PH_CHECK
    } phase_t;

    typedef struct packed {
        logic  vld;
        byte_t val;
    } byte_evt_t;

    function automatic byte_t sum8(byte_t a, byte_t b);
        return a + b;
    endfunction

endpackage

// File: rtl/sync_hunt.sv
module sync_hunt #(
    parameter int               WIN_W = 16,
    parameter logic [WIN_W-1:0] SYNC  = 16'h09AF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bit_vld,
    input  logic bit_in,
    output logic hit
);
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_nx;

    assign win_nx = {win_q[WIN_W-2:0], bit_in};
    assign hit    = en && bit_vld && (win_nx == SYNC);

    always_ff @(posedge clk) begin
        if (rst || !en || hit) begin
            win_q <= '0;
        end else if (bit_vld) begin
            win_q <= win_nx;
        end
    end

    AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && !bit_vld && !$past(rst)) |=> $stable(win_q)); // R2

endmodule

// File: rtl/byte_packer.sv
module byte_packer
    import dfr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      bit_vld,
    input  logic      bit_in,
    output byte_evt_t evt
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] sh_q;
    logic              full;

    assign full    = (cnt_q == CNT_W'(BYTE_W - 1));
    assign evt.vld = en && bit_vld && full;
    assign evt.val = {sh_q, bit_in};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (bit_vld) begin
            sh_q  <= {sh_q[BYTE_W-3:0], bit_in};
            cnt_q <= full ? '0 : cnt_q + CNT_W'(1);
        end
    end

    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (en && bit_vld && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1) || !en)); // R3

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import dfr_pkg::*;
#(
    parameter int MAX_LEN = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  byte_evt_t evt,
    input  byte_t     station_addr,
    output logic      hunting,
    output byte_t     byte_out,
    output logic      byte_vld,
    output logic      frame_done,
    output logic      addr_match,
    output logic      csum_err
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    phase_t           ph_q;
    byte_t            sum_q;
    logic [LEN_W-1:0] left_q;

    assign hunting = (ph_q == PH_HUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_HUNT;
            sum_q      <= '0;
            left_q     <= '0;
            byte_out   <= '0;
            byte_vld   <= 1'b0;
            frame_done <= 1'b0;
            csum_err   <= 1'b0;
            addr_match <= 1'b0;
        end else begin
            byte_vld   <= 1'b0;
            frame_done <= 1'b0;
            csum_err   <= 1'b0;
            case (ph_q)
                PH_HUNT: begin
                    if (hit) begin
                        ph_q       <= PH_ADDR;
                        addr_match <= 1'b0;
                    end
                end
                PH_ADDR: begin
                    if (evt.vld) begin
                        sum_q      <= evt.val;
                        addr_match <= (evt.val == station_addr);
                        ph_q       <= PH_LEN;
                    end
                end
                PH_LEN: begin
                    if (evt.vld) begin
                        if (int'(evt.val) > MAX_LEN) begin
                            ph_q       <= PH_HUNT;
                            addr_match <= 1'b0;
                        end else begin
                            sum_q  <= sum8(sum_q, evt.val);
                            left_q <= LEN_W'(evt.val);
                            ph_q   <= (evt.val == '0) ? PH_CHECK : PH_BODY;
                        end
                    end
                end
                PH_BODY: begin
                    if (evt.vld) begin
                        sum_q  <= sum8(sum_q, evt.val);
                        left_q <= left_q - LEN_W'(1);
                        if (addr_match) begin
                            byte_out <= evt.val;
                            byte_vld <= 1'b1;
                        end
                        if (left_q == LEN_W'(1)) begin
                            ph_q <= PH_CHECK;
                        end
                    end
                end
                PH_CHECK: begin
                    if (evt.vld) begin
                        frame_done <= 1'b1;
                        csum_err   <= (evt.val != sum_q);
                        ph_q       <= PH_HUNT;
                    end
                end
                default: ph_q <= PH_HUNT;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R7
    AST_DONE_FROM_CHECK: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> ($past(ph_q) == PH_CHECK)); // R7
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        csum_err |-> frame_done); // R8
    AST_BYTE_OWN_ADDR: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> addr_match); // R6
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(left_q) <= MAX_LEN); // R5
    AST_HUNT_WAITS: assert property (@(posedge clk) disable iff (rst)
        (hunting && !hit) |=> hunting); // R2

endmodule

// File: rtl/sync_frame_deframer.sv
module sync_frame_deframer
    import dfr_pkg::*;
#(
    parameter int               WIN_W     = 16,
    parameter logic [WIN_W-1:0] SYNC_WORD = 16'h09AF,
    parameter int               MAX_LEN   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic [BYTE_W-1:0] station_addr,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld,
    output logic              frame_done,
    output logic              addr_match,
    output logic              csum_err
);
    logic      hunting;
    logic      hit;
    byte_evt_t evt;

    sync_hunt #(
        .WIN_W (WIN_W),
        .SYNC  (SYNC_WORD)
    ) u_hunt (
        .clk     (clk),
        .rst     (rst),
        .en      (hunting),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .hit     (hit)
    );

    byte_packer u_pack (
        .clk     (clk),
        .rst     (rst),
        .en      (!hunting),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .evt     (evt)
    );

    frame_fsm #(
        .MAX_LEN (MAX_LEN)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .hit          (hit),
        .evt          (evt),
        .station_addr (station_addr),
        .hunting      (hunting),
        .byte_out     (byte_out),
        .byte_vld     (byte_vld),
        .frame_done   (frame_done),
        .addr_match   (addr_match),
        .csum_err     (csum_err)
    );

endmodule

// File: tb/sim_sync_frame_deframer.sv
module sim_sync_frame_deframer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic [7:0] station_addr = 8'h3C;
    logic [7:0] byte_out;
    logic       byte_vld, frame_done, addr_match, csum_err;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] payload [0:79];
    logic [7:0] rx [0:79];
    int         rx_n = 0;
    int         done_n = 0;
    logic       last_err = 1'b0;
    logic       last_match = 1'b0;

    always #2 clk = ~clk;

    sync_frame_deframer u0 (
        .clk          (clk),
        .rst          (rst),
        .bit_in       (bit_in),
        .bit_vld      (bit_vld),
        .station_addr (station_addr),
        .byte_out     (byte_out),
        .byte_vld     (byte_vld),
        .frame_done   (frame_done),
        .addr_match   (addr_match),
        .csum_err     (csum_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld) begin
                if (rx_n < 80) rx[rx_n] = byte_out;
                rx_n = rx_n + 1;
            end
            if (frame_done) begin
                done_n     = done_n + 1;
                last_err   = csum_err;
                last_match = addr_match;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one strobed bit from a falling edge; returns at the falling
    // edge after the sampling edge plus gap idle cycles with junk on bit_in.
    task automatic send_bit(input logic b, input int gap);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
        for (int g = 0; g < gap; g++) begin
            bit_in = 1'($urandom);
            @(negedge clk);
        end
    endtask

    // Last bit has no gap: on return the byte's result is visible.
    task automatic send_byte(input logic [7:0] v, input int maxgap);
        for (int i = 7; i >= 0; i--) begin
            send_bit(v[i], (i == 0) ? 0 : $urandom_range(0, maxgap));
        end
    endtask

    task automatic send_header(input int ones);
        for (int i = 0; i < ones; i++) send_bit(1'b1, 0);
        send_byte(8'h09, 1);
        send_byte(8'hAF, 1);
    endtask

    task automatic send_frame(input logic [7:0] addr, input int len, input logic bad,
                              input int maxgap, input int ones);
        logic [7:0] cs;
        cs = addr + 8'(len);
        for (int i = 0; i < len; i++) cs = cs + payload[i];
        if (bad) cs = cs ^ 8'h5A;
        send_header(ones);
        send_byte(addr, maxgap);
        send_byte(8'(len), maxgap);
        for (int i = 0; i < len; i++) send_byte(payload[i], maxgap);
        send_byte(cs, maxgap);
    endtask

    task automatic clear_mon();
        rx_n = 0;
        done_n = 0;
        last_err = 1'b0;
        last_match = 1'b0;
    endtask

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) payload[i] = 8'((seed * 37 + i * 91 + 5) & 255);
    endtask

    task automatic t_reset();
        check("R1", "byte_vld", int'(byte_vld), 0);
        check("R1", "frame_done", int'(frame_done), 0);
        check("R1", "csum_err", int'(csum_err), 0);
        check("R1", "addr_match", int'(addr_match), 0);
    endtask

    task automatic t_good();
        clear_mon();
        fill(5, 1);
        send_frame(8'h3C, 5, 1'b0, 2, 37);
        check("R7", "frame_done on time", int'(frame_done), 1);
        check("R8", "csum_err on time", int'(csum_err), 0);
        @(negedge clk);
        check("R2", "frames after offset header", done_n, 1);
        check("R6", "byte count", rx_n, 5);
        for (int i = 0; i < 5; i++) check("R3", "body byte", int'(rx[i]), int'(payload[i]));
        check("R4", "match at done", int'(last_match), 1);
    endtask

    task automatic t_foreign();
        clear_mon();
        fill(3, 2);
        send_frame(8'h55, 3, 1'b0, 1, 40);
        check("R7", "done for foreign frame", int'(frame_done), 1);
        @(negedge clk);
        check("R6", "no bytes for foreign frame", rx_n, 0);
        check("R4", "foreign match flag", int'(last_match), 0);
        check("R8", "foreign csum ok", int'(last_err), 0);
    endtask

    task automatic t_badsum();
        clear_mon();
        fill(4, 3);
        send_frame(8'h3C, 4, 1'b1, 2, 40);
        check("R8", "csum_err on bad check", int'(csum_err), 1);
        @(negedge clk);
        check("R8", "csum_err cleared", int'(csum_err), 0);
        check("R7", "done count bad frame", done_n, 1);
    endtask

    task automatic t_zero_len();
        clear_mon();
        send_frame(8'h3C, 0, 1'b0, 0, 40);
        check("R10", "done for empty body", int'(frame_done), 1);
        @(negedge clk);
        check("R10", "no bytes for empty body", rx_n, 0);
        check("R10", "csum empty body", int'(last_err), 0);
    endtask

    task automatic t_max_len();
        int bad;
        clear_mon();
        fill(64, 4);
        send_frame(8'h3C, 64, 1'b0, 0, 40);
        check("R5", "done at length 64", int'(frame_done), 1);
        @(negedge clk);
        check("R5", "byte count 64", rx_n, 64);
        bad = 0;
        for (int i = 0; i < 64; i++) if (rx[i] !== payload[i]) bad = bad + 1;
        check("R5", "length 64 contents mismatches", bad, 0);
    endtask

    task automatic t_abort();
        clear_mon();
        send_header(40);
        send_byte(8'h3C, 1);
        check("R4", "match after address byte", int'(addr_match), 1);
        send_byte(8'd65, 1);
        check("R5", "match cleared on abort", int'(addr_match), 0);
        for (int i = 0; i < 4; i++) send_byte(8'h00, 1);
        repeat (3) @(negedge clk);
        check("R5", "no done after abort", done_n, 0);
        check("R5", "no bytes after abort", rx_n, 0);
        fill(2, 5);
        send_frame(8'h3C, 2, 1'b0, 1, 8);
        check("R5", "frame after abort done", int'(frame_done), 1);
    endtask

    task automatic t_window();
        clear_mon();
        fill(1, 6);
        send_frame(8'h3C, 1, 1'b0, 0, 20);
        @(negedge clk);
        clear_mon();
        send_byte(8'hAF, 0);
        send_byte(8'h3C, 0);
        send_byte(8'h00, 0);
        send_byte(8'h3C, 0);
        repeat (2) @(negedge clk);
        check("R9", "lone AF after frame ignored", done_n, 0);
        clear_mon();
        fill(2, 7);
        send_frame(8'h3C, 2, 1'b0, 0, 0);
        check("R9", "header right after restart", int'(frame_done), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good();
        t_foreign();
        t_badsum();
        t_zero_len();
        t_max_len();
        t_abort();
        t_window();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule